// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block produces a single-error-correcting parity code for one 512-byte data block as it streams past on an 8-bit byte bus. A start pulse clears the previous result and opens a new calculation. Each accepted byte is folded into two 12-bit parity halves. The first half tracks every data bit position in true sense. The second half tracks the complement of every position. One cycle after the 512th byte, the block presents a registered 24-bit code with a valid flag.

The code is the concatenation {true half, complement half}, bitwise inverted. A fully erased block of all-ones bytes therefore yields 0xFFFFFF, which is the same value an erased spare area holds, so an erased page checks clean. Byte 0 of the code (bits 7:0) is the first byte to be stored.

A separate compare port takes a stored code and a freshly computed code and classifies their XOR difference. The classes are: clean, a single data-bit error (with a byte offset and a bit mask to XOR into the buffer), an error confined to the code bits, or uncorrectable. The block never touches the data buffer itself.

Top module: `nand_hecc_engine`

## Requirements
- R1: After reset, code_valid, byte_overflow and cmp_done are 0, code_out is 0 and cmp_status is 0 (clean).
- R2: For byte offset a (0..511) and bit index b (0..7), let position p = {a, b} (12 bits, b in bits 2:0). Bit k of the true half is the XOR of all data bits whose p has bit k set. Bit k of the complement half is the XOR of all data bits whose p has bit k clear. code_out equals the bitwise inverse of {true half in bits 23:12, complement half in bits 11:0}. Byte 0 of the code is bits 7:0.
- R3: code_valid is 0 until the 512th byte after a start is accepted, and it is 1 in the cycle after that byte's clock edge. From then until the next start, code_valid and code_out hold their values.
- R4: A block of 512 bytes that are all 0xFF gives code_out = 0xFFFFFF.
- R5: A cycle with blk_start high clears the calculation. In the next cycle code_valid and byte_overflow are 0. A byte presented in the same cycle as blk_start is not included in the code.
- R6: A byte presented after the 512th byte and before the next start sets byte_overflow in the next cycle and leaves code_out unchanged.
- R7: Cycles with byte_valid low do not advance the byte offset and do not change the code.
- R8: If cmp_stored equals cmp_calc, cmp_status is 0 (clean), and cmp_offset and cmp_mask are 0.
- R9: Let d = cmp_stored XOR cmp_calc. If d[23:12] XOR d[11:0] equals 0xFFF, cmp_status is 1 (corrected), cmp_offset = d[23:15] and cmp_mask = 1 << d[14:12]. An offset of 512 or more is reported as status 3.
- R10: If exactly one bit of d is set, cmp_status is 2 (error in the code), and cmp_offset and cmp_mask are 0.
- R11: Any other nonzero d gives cmp_status 3 (uncorrectable), with cmp_offset and cmp_mask 0.
- R12: The compare result appears one cycle after cmp_valid. cmp_done is high in exactly the cycles that follow a cycle with cmp_valid high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Clears the result and begins a new block |
| byte_valid | input | 1 | byte_data carries a data byte this cycle |
| byte_data | input | 8 | Streamed data byte |
| code_out | output | 24 | Packed, inverted parity code (0 while not valid) |
| code_valid | output | 1 | code_out holds the code of a complete block |
| byte_overflow | output | 1 | A byte arrived after the block was complete |
| cmp_valid | input | 1 | Compare request |
| cmp_stored | input | 24 | Code read back from storage |
| cmp_calc | input | 24 | Code computed over the read data |
| cmp_done | output | 1 | Compare result valid this cycle |
| cmp_status | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| cmp_offset | output | 9 | Byte offset of the corrected bit |
| cmp_mask | output | 8 | XOR mask for the corrected byte |

## Verification
The assertions assume that blk_start, byte_valid, cmp_valid and the compare code inputs are known values whenever reset is low. They also assume that a byte offered after block completion is a real spill rather than a don't-care. The stimulus drives every input from tasks half a cycle away from the sampling edge, and all inputs stay at defined levels between operations. Random compare pairs are built either from real block codes with injected bit flips or from fully random differences, so that all four status classes are reached without leaving the defined input space.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    CHK_CLEAN = 2'd0,
    CHK_FIXED = 2'd1,
    CHK_CODE  = 2'd2,
    CHK_FATAL = 2'd3
  } chk_status_t;

endpackage

// File: rtl/hecc_accum.sv
// Streaming parity accumulator: folds each accepted byte into a true-sense
// and a complement-sense parity half indexed by {byte offset, bit index}.
module hecc_accum #(
  parameter int BLOCK_BYTES = 512,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(DATA_W),
  localparam int HALF_W     = ADDR_W + IDX_W,
  localparam int CNT_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic [HALF_W-1:0] true_next,
  output logic [HALF_W-1:0] comp_next,
  output logic              last_take,
  output logic              spill
);

  logic [CNT_W-1:0]  count_q;
  logic [HALF_W-1:0] true_q, comp_q;
  logic [HALF_W-1:0] add_true, add_comp;
  logic [ADDR_W-1:0] addr;
  logic              full, accept, byte_par;

  assign full     = (count_q == CNT_W'(BLOCK_BYTES));
  assign accept   = take && !full && !clear;
  assign addr     = count_q[ADDR_W-1:0];
  assign byte_par = ^data;

  // bit-index part of each half
  for (genvar j = 0; j < IDX_W; j++) begin : g_idx
    logic [DATA_W-1:0] sel;
    for (genvar b = 0; b < DATA_W; b++) begin : g_sel
      assign sel[b] = (((b >> j) % 2) == 1);
    end
    assign add_true[j] = ^(data & sel);
    assign add_comp[j] = ^(data & ~sel);
  end

  // byte-offset part of each half
  for (genvar k = 0; k < ADDR_W; k++) begin : g_addr
    assign add_true[IDX_W+k] = addr[k] & byte_par;
    assign add_comp[IDX_W+k] = ~addr[k] & byte_par;
  end

  always_comb begin
    true_next = true_q;
    comp_next = comp_q;
    if (accept) begin
      true_next = true_q ^ add_true;
      comp_next = comp_q ^ add_comp;
    end
  end

  assign last_take = accept && (count_q == CNT_W'(BLOCK_BYTES - 1));
  assign spill     = take && full && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
      true_q  <= '0;
      comp_q  <= '0;
    end else begin
      true_q <= true_next;
      comp_q <= comp_next;
      if (accept) count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/hecc_result.sv
// Holds the packed, inverted code and the completion / spill flags.
module hecc_result #(
  parameter int HALF_W = 12,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic              spill,
  input  logic [HALF_W-1:0] true_half,
  input  logic [HALF_W-1:0] comp_half,
  output logic [CODE_W-1:0] code,
  output logic              valid,
  output logic              overflow
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code     <= '0;
      valid    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (capture) begin
        code  <= ~{true_half, comp_half};
        valid <= 1'b1;
      end
      if (spill) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/hecc_compare.sv
// Classifies stored-vs-computed code difference, registered result.
module hecc_compare
  import hecc_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(DATA_W),
  localparam int HALF_W     = ADDR_W + IDX_W,
  localparam int CODE_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] calc,
  output logic              done,
  output chk_status_t       status,
  output logic [ADDR_W-1:0] offset,
  output logic [DATA_W-1:0] mask
);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  bsel;
  logic              is_zero, is_fold, is_single, in_range;
  chk_status_t       st_d;
  logic [ADDR_W-1:0] off_d;
  logic [DATA_W-1:0] mask_d;

  assign diff      = stored ^ calc;
  assign fold      = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign offs      = diff[CODE_W-1:HALF_W+IDX_W];
  assign bsel      = diff[HALF_W+IDX_W-1:HALF_W];
  assign is_zero   = (diff == '0);
  assign is_fold   = &fold;
  assign is_single = !is_zero && ((diff & (diff - 1'b1)) == '0);
  assign in_range  = (int'(offs) < BLOCK_BYTES);

  always_comb begin
    st_d   = CHK_FATAL;
    off_d  = '0;
    mask_d = '0;
    if (is_zero) begin
      st_d = CHK_CLEAN;
    end else if (is_fold) begin
      if (in_range) begin
        st_d   = CHK_FIXED;
        off_d  = offs;
        mask_d = DATA_W'(1) << bsel;
      end
    end else if (is_single) begin
      st_d = CHK_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      status <= CHK_CLEAN;
      offset <= '0;
      mask   <= '0;
    end else begin
      done <= req;
      if (req) begin
        status <= st_d;
        offset <= off_d;
        mask   <= mask_d;
      end
    end
  end

endmodule

// File: rtl/nand_hecc_engine.sv
module nand_hecc_engine
  import hecc_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(DATA_W),
  localparam int HALF_W     = ADDR_W + IDX_W,
  localparam int CODE_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic [CODE_W-1:0] code_out,
  output logic              code_valid,
  output logic              byte_overflow,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_stored,
  input  logic [CODE_W-1:0] cmp_calc,
  output logic              cmp_done,
  output logic [1:0]        cmp_status,
  output logic [ADDR_W-1:0] cmp_offset,
  output logic [DATA_W-1:0] cmp_mask
);

  logic [HALF_W-1:0] true_next, comp_next;
  logic              last_take, spill;
  chk_status_t       status_e;

  hecc_accum #(.BLOCK_BYTES(BLOCK_BYTES), .DATA_W(DATA_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clear     (blk_start),
    .take      (byte_valid),
    .data      (byte_data),
    .true_next (true_next),
    .comp_next (comp_next),
    .last_take (last_take),
    .spill     (spill)
  );

  hecc_result #(.HALF_W(HALF_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .clear     (blk_start),
    .capture   (last_take),
    .spill     (spill),
    .true_half (true_next),
    .comp_half (comp_next),
    .code      (code_out),
    .valid     (code_valid),
    .overflow  (byte_overflow)
  );

  hecc_compare #(.BLOCK_BYTES(BLOCK_BYTES), .DATA_W(DATA_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .req    (cmp_valid),
    .stored (cmp_stored),
    .calc   (cmp_calc),
    .done   (cmp_done),
    .status (status_e),
    .offset (cmp_offset),
    .mask   (cmp_mask)
  );

  assign cmp_status = status_e;

endmodule

// File: rtl/hecc_engine_chk.sv
module hecc_engine_chk #(
  parameter int CODE_W = 24,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_start,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_data,
  input logic [CODE_W-1:0] code_out,
  input logic              code_valid,
  input logic              byte_overflow,
  input logic              cmp_valid,
  input logic [CODE_W-1:0] cmp_stored,
  input logic [CODE_W-1:0] cmp_calc,
  input logic              cmp_done,
  input logic [1:0]        cmp_status,
  input logic [ADDR_W-1:0] cmp_offset,
  input logic [DATA_W-1:0] cmp_mask
);

  p_idle_code_r1: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> (code_out == '0));

  p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !blk_start) |=> (code_valid && $stable(code_out)));

  p_start_clear_r5: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> (!code_valid && !byte_overflow));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (code_valid && byte_valid && !blk_start) |=> byte_overflow);

  p_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && (cmp_stored == cmp_calc)) |=> (cmp_status == 2'd0));

  p_fix_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_status == 2'd1) |-> ($countones(cmp_mask) == 1));

  p_code_err_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && $countones(cmp_stored ^ cmp_calc) == 1) |=> (cmp_status == 2'd2));

  p_nofix_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_status != 2'd1) |-> (cmp_mask == '0 && cmp_offset == '0));

  p_done_rise_r12: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> cmp_done);

  p_done_fall_r12: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> !cmp_done);

endmodule

bind nand_hecc_engine hecc_engine_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/nand_hecc_engine_test.sv
module nand_hecc_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [23:0] code_out;
  logic        code_valid, byte_overflow;
  logic        cmp_valid = 1'b0;
  logic [23:0] cmp_stored = '0, cmp_calc = '0;
  logic        cmp_done;
  logic [1:0]  cmp_status;
  logic [8:0]  cmp_offset;
  logic [7:0]  cmp_mask;

  int checks = 0;
  int errors = 0;
  logic [7:0] blk [512];

  always #10 clk = ~clk;

  nand_hecc_engine uut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .code_out(code_out), .code_valid(code_valid),
    .byte_overflow(byte_overflow), .cmp_valid(cmp_valid),
    .cmp_stored(cmp_stored), .cmp_calc(cmp_calc), .cmp_done(cmp_done),
    .cmp_status(cmp_status), .cmp_offset(cmp_offset), .cmp_mask(cmp_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code();
    logic [11:0] t, c, p;
    t = '0; c = '0;
    for (int a = 0; a < 512; a++)
      for (int b = 0; b < 8; b++)
        if (blk[a][b]) begin
          p = {a[8:0], b[2:0]};
          t ^= p;
          c ^= ~p;
        end
    return ~{t, c};
  endfunction

  // returns {status[1:0], offset[8:0], mask[7:0]}
  function automatic logic [18:0] ref_cmp(input logic [23:0] s, input logic [23:0] k);
    logic [23:0] d;
    d = s ^ k;
    if (d == 0) return 19'd0;
    if ((d[23:12] ^ d[11:0]) == 12'hFFF)
      return {2'd1, d[23:15], 8'(8'd1 << d[14:12])};
    if ($countones(d) == 1) return {2'd2, 17'd0};
    return {2'd3, 17'd0};
  endfunction

  task automatic start_blk(input logic with_byte);
    blk_start = 1'b1;
    byte_valid = with_byte;
    byte_data = 8'hA5;
    @(negedge clk);
    blk_start = 1'b0;
    byte_valid = 1'b0;
    chk("R5 valid cleared", 32'(code_valid), 0);
    chk("R5 overflow cleared", 32'(byte_overflow), 0);
  endtask

  task automatic feed_blk(input bit gaps, input string req);
    for (int i = 0; i < 512; i++) begin
      if (i == 511) chk("R3 not valid before last byte", 32'(code_valid), 0);
      byte_data = blk[i];
      byte_valid = 1'b1;
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        byte_valid = 1'b0;
        byte_data = $urandom;
        repeat (1 + $urandom % 3) @(negedge clk);
      end
    end
    byte_valid = 1'b0;
    chk("R3 valid after last byte", 32'(code_valid), 1);
    chk(req, 32'(code_out), 32'(ref_code()));
  endtask

  task automatic compare(input logic [23:0] s, input logic [23:0] k, input string req);
    logic [18:0] e;
    e = ref_cmp(s, k);
    cmp_stored = s; cmp_calc = k; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    chk("R12 done after request", 32'(cmp_done), 1);
    chk(req, 32'({cmp_status, cmp_offset, cmp_mask}), 32'(e));
    @(negedge clk);
    chk("R12 done drops", 32'(cmp_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] good, bad, held;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code_valid", 32'(code_valid), 0);
    chk("R1 code_out", 32'(code_out), 0);
    chk("R1 overflow", 32'(byte_overflow), 0);
    chk("R1 cmp_done", 32'(cmp_done), 0);
    chk("R1 cmp_status", 32'(cmp_status), 0);

    // R2/R7 random block with idle gaps
    for (int i = 0; i < 512; i++) blk[i] = $urandom;
    start_blk(1'b0);
    feed_blk(1'b1, "R2 R7 random block with gaps");

    // R6 spill bytes after completion
    held = code_out;
    byte_valid = 1'b1; byte_data = 8'h3C;
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R6 overflow set", 32'(byte_overflow), 1);
    chk("R6 code unchanged", 32'(code_out), 32'(held));
    chk("R3 valid held", 32'(code_valid), 1);

    // R4 erased block
    for (int i = 0; i < 512; i++) blk[i] = 8'hFF;
    start_blk(1'b0);
    feed_blk(1'b0, "R4 erased block");
    chk("R4 all ones", 32'(code_out), 32'h00FFFFFF);

    // R5 byte in start cycle ignored; ramp pattern
    for (int i = 0; i < 512; i++) blk[i] = 8'(i * 7 + 3);
    start_blk(1'b1);
    feed_blk(1'b0, "R5 R2 start-cycle byte excluded");
    good = code_out;

    // R8 clean compare
    compare(good, good, "R8 clean compare");

    // R9 single data-bit flips at corners and random spots
    for (int n = 0; n < 4; n++) begin
      int a, b;
      a = (n == 0) ? 0 : (n == 1) ? 511 : int'($urandom % 512);
      b = (n == 0) ? 0 : (n == 1) ? 7 : int'($urandom % 8);
      blk[a][b] = ~blk[a][b];
      bad = ref_code();
      blk[a][b] = ~blk[a][b];
      compare(good, bad, "R9 single data bit");
      chk("R9 offset", 32'(cmp_offset), 32'(a));
      chk("R9 mask", 32'(cmp_mask), 32'(1 << b));
    end

    // R10 single code-bit flips
    compare(good, good ^ 24'h000001, "R10 code bit 0");
    compare(good, good ^ 24'h800000, "R10 code bit 23");

    // R11 two data bits flipped
    blk[10][1] = ~blk[10][1];
    blk[300][6] = ~blk[300][6];
    bad = ref_code();
    compare(good, bad, "R11 two data bits");
    chk("R11 status", 32'(cmp_status), 3);

    // random compare pairs
    for (int n = 0; n < 40; n++) begin
      logic [23:0] s;
      s = 24'($urandom);
      case ($urandom % 3)
        0: compare(s, s ^ {12'($urandom), ~12'($urandom)}, "R9 R11 random pair");
        1: compare(s, s ^ (24'd1 << ($urandom % 24)), "R10 random single");
        default: compare(s, 24'($urandom), "R11 random pair");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule